// File: doc/BRIEF.md
# Legacy Serial Port Register Bank

This block is the host-facing register file of a single-buffered, PC-style serial port. A host reaches eight byte-wide locations through a 3-bit address, a strobe and a write flag. Read data is combinational from the current register state. Each read or write takes effect on the clock edge where the strobe is high.

A receiver deposits bytes and break events into the bank. A transmitter picks up each byte the host writes from a one-cycle strobe. The bank decides which interrupt source is pending and presents it as a registered identification byte and a level interrupt line. Bit-level serialisation, baud timing and FIFOs live in neighbouring blocks, which take their configuration from the divisor and line-control outputs.

A hidden pending flag tracks the transmit-empty interrupt. Reading the identification location while it reports the transmit source drops that flag. Rewriting the enable register while the holding register is empty sets the flag again.

Top module: `sio_regbank`

## Requirements
- R1: After reset the line status byte (address 5) reads 0x60, the identification byte (address 2) reads 0x01, irq is low, rx_ready is high, and the divisor and enable register read 0.
- R2: With line-control bit 7 set, addresses 0 and 1 read and write the low and high divisor bytes, which appear on cfg_divisor, and no transmit strobe is issued. With bit 7 clear, address 0 is receive/transmit data and address 1 is the interrupt enable register.
- R3: The interrupt enable register stores only bits 3:0 (bit 0 receive data, bit 1 transmit empty); bits 7:4 read 0.
- R4: The identification byte is 0x04 when data-ready and enable bit 0 are both set. Otherwise it is 0x02 when the transmit pending flag and enable bit 1 are both set. Otherwise it is 0x01. irq is high exactly when the identification byte is not 0x01.
- R5: A read of address 2 returns the identification byte. If its bits 2:0 equal 0x2, the transmit pending flag is cleared and the identification is re-evaluated. Any other value leaves the flag unchanged.
- R6: A data write (address 0, bit 7 of line control clear) raises tx_valid for exactly one cycle with the byte on tx_byte. It sets the transmit pending flag, and line status bits 5 and 6 read as 1 afterwards.
- R7: A write to the interrupt enable register while line status bit 5 is set sets the transmit pending flag.
- R8: A receive byte is taken only while rx_ready is high; it sets line status bit 0 and drops rx_ready. A byte offered while rx_ready is low is discarded. A read of address 0 returns the held byte and clears line status bits 0 and 4.
- R9: A break event loads 0 into the receive byte and sets line status bits 4 and 0.
- R10: Modem control (address 4) keeps bits 4:0. With bit 4 set, address 6 reads control bits 3:2 on bits 7:6, bit 1 on bit 4 and bit 0 on bit 5, and 0 elsewhere.
- R11: Writes to addresses 2 and 5 change nothing. Address 7 is a free scratch byte. Address 6 returns the last byte written to it when loopback is off. Address 3 reads back all 8 bits.
- R12: The identification byte and irq are registered and reflect the state as it stands after the same clock edge that performs the access or receive event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| rx_valid | input | 1 | Receiver offers rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Receiver saw a break condition |
| rx_ready | output | 1 | Bank can take a new byte |
| tx_valid | output | 1 | One-cycle strobe for a byte to send |
| tx_byte | output | 8 | Byte to send |
| cfg_divisor | output | 16 | Current divisor value |
| cfg_line | output | 8 | Current line-control byte |
| irq_id | output | 8 | Registered interrupt identification |
| irq | output | 1 | Level interrupt request |

## Verification
The directed scenarios target the pending-flag corner cases. Reading the identification byte while it shows 0x04 must not drop the transmit flag, or the transmit interrupt would never return once the receive byte is consumed. A second ID read after clearing must show 0x01; a design that clears the flag on every read, or never clears it, would show 0x02 again or silently lose an interrupt. A byte offered while data is already held must leave the held value untouched, or the design would overwrite unread data. Loopback readback is checked with patterns that separate every moved bit, so a swapped bit 4/bit 5 mapping shows up in the value read back.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_IEN  = 3'd1;
   localparam logic [2:0] A_IID  = 3'd2;
   localparam logic [2:0] A_LCTL = 3'd3;
   localparam logic [2:0] A_MCTL = 3'd4;
   localparam logic [2:0] A_LSTA = 3'd5;
   localparam logic [2:0] A_MSTA = 3'd6;
   localparam logic [2:0] A_SCR  = 3'd7;

   localparam logic [7:0] ID_NONE = 8'h01;
   localparam logic [7:0] ID_TX   = 8'h02;
   localparam logic [7:0] ID_RX   = 8'h04;

   localparam int LC_DLAB  = 7;
   localparam int MC_LOOP  = 4;
   localparam int IE_RX    = 0;
   localparam int IE_TX    = 1;
endpackage

// File: rtl/sio_divlatch.sv
module sio_divlatch #(
   parameter int DIV_BYTES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_lo,
   input  logic                   wr_hi,
   input  logic [7:0]             wdata,
   output logic [7:0]             div_lo,
   output logic [7:0]             div_hi,
   output logic [8*DIV_BYTES-1:0] div_val
);
   localparam int DIV_W = 8 * DIV_BYTES;

   logic [7:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= '0;
      else if (wr_lo) lo_q <= wdata;
   end
   assign div_lo = lo_q;

   generate
      if (DIV_BYTES == 2) begin : g_two
         logic [7:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_hi) hi_q <= wdata;
         end
         assign div_hi  = hi_q;
         assign div_val = {hi_q, lo_q};
      end else begin : g_one
         logic unused_hi;
         assign unused_hi = wr_hi;
         assign div_hi  = 8'h00;
         assign div_val = DIV_W'(lo_q);
      end
   endgenerate
endmodule

// File: rtl/sio_irq_eval.sv
module sio_irq_eval
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_tx,
   input  logic       set_ien,
   input  logic       thre_nx,
   input  logic       clr_rd,
   input  logic       dr_nx,
   input  logic       rx_en_nx,
   input  logic       tx_en_nx,
   output logic [7:0] id_q,
   output logic       irq_q
);
   logic       pend_q, pend_n;
   logic [7:0] id_n;

   always_comb begin
      pend_n = pend_q;
      if (clr_rd && id_q[2:0] == ID_TX[2:0]) pend_n = 1'b0;
      if (set_tx)                            pend_n = 1'b1;
      if (set_ien && thre_nx)                pend_n = 1'b1;
   end

   always_comb begin
      if (dr_nx && rx_en_nx)        id_n = ID_RX;
      else if (pend_n && tx_en_nx)  id_n = ID_TX;
      else                          id_n = ID_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         id_q   <= ID_NONE;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_n;
         id_q   <= id_n;
         irq_q  <= (id_n != ID_NONE);
      end
   end

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (id_q != ID_NONE)); // R4
   AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(id_q) && id_q != 8'h00 && id_q[7:3] == 5'b0); // R4
   AST_RD_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd && id_q == ID_TX && !set_tx && !set_ien) |=> id_q != ID_TX); // R5
endmodule

// File: rtl/sio_modem_view.sv
module sio_modem_view #(
   parameter int  MCR_BITS = 5,
   parameter bit  LOOP_EN  = 1'b1
) (
   input  logic [MCR_BITS-1:0] mctl,
   input  logic [7:0]          msta,
   output logic [7:0]          view
);
   generate
      if (LOOP_EN) begin : g_loop
         always_comb begin
            view = msta;
            if (mctl[sio_pkg::MC_LOOP]) begin
               view      = 8'h00;
               view[7:6] = mctl[3:2];
               view[4]   = mctl[1];
               view[5]   = mctl[0];
            end
         end
      end else begin : g_plain
         logic [MCR_BITS-1:0] unused_mctl;
         assign unused_mctl = mctl;
         assign view = msta;
      end
   endgenerate
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
   import sio_pkg::*;
#(
   parameter int DIV_BYTES = 2,
   parameter int IER_BITS  = 4,
   parameter int MCR_BITS  = 5,
   parameter bit LOOP_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic        rx_break,
   output logic        rx_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_byte,
   output logic [15:0] cfg_divisor,
   output logic [7:0]  cfg_line,
   output logic [7:0]  irq_id,
   output logic        irq
);
   localparam int DIV_W = 8 * DIV_BYTES;

   generate
      if (DIV_BYTES < 1 || DIV_BYTES > 2) begin : g_bad_div
         $error("DIV_BYTES must be 1 or 2");
      end
      if (IER_BITS < 2 || IER_BITS > 8) begin : g_bad_ier
         $error("IER_BITS must be 2..8");
      end
      if (MCR_BITS < 5 || MCR_BITS > 8) begin : g_bad_mcr
         $error("MCR_BITS must be 5..8");
      end
   endgenerate

   logic [7:0]          lctl_q, msta_q, scr_q, rbr_q, rbr_n;
   logic [IER_BITS-1:0] ien_q, ien_n;
   logic [MCR_BITS-1:0] mctl_q;
   logic                dr_q, dr_n, bi_q, bi_n, thre_q, temt_q;
   logic                tx_v_q;
   logic [7:0]          tx_b_q;
   logic [7:0]          lsta, msta_view, div_lo, div_hi;
   logic [DIV_W-1:0]    div_val;

   logic dlab, rd, wr;
   logic wr_thr, wr_dll, wr_dlh, wr_ien, wr_lctl, wr_mctl, wr_msta, wr_scr;
   logic rd_rbr, rd_iid, rx_take;

   assign dlab = lctl_q[LC_DLAB];
   assign rd   = bus_sel & ~bus_wr;
   assign wr   = bus_sel &  bus_wr;

   assign wr_thr  = wr && bus_addr == A_DATA && !dlab;
   assign wr_dll  = wr && bus_addr == A_DATA &&  dlab;
   assign wr_ien  = wr && bus_addr == A_IEN  && !dlab;
   assign wr_dlh  = wr && bus_addr == A_IEN  &&  dlab;
   assign wr_lctl = wr && bus_addr == A_LCTL;
   assign wr_mctl = wr && bus_addr == A_MCTL;
   assign wr_msta = wr && bus_addr == A_MSTA;
   assign wr_scr  = wr && bus_addr == A_SCR;
   assign rd_rbr  = rd && bus_addr == A_DATA && !dlab;
   assign rd_iid  = rd && bus_addr == A_IID;
   assign rx_take = rx_valid && !dr_q;

   // receive side next state: break beats a byte, both beat a read clear
   always_comb begin
      rbr_n = rbr_q;
      dr_n  = dr_q;
      bi_n  = bi_q;
      if (rd_rbr) begin
         dr_n = 1'b0;
         bi_n = 1'b0;
      end
      if (rx_take) begin
         rbr_n = rx_byte;
         dr_n  = 1'b1;
      end
      if (rx_break) begin
         rbr_n = 8'h00;
         dr_n  = 1'b1;
         bi_n  = 1'b1;
      end
   end

   assign ien_n = wr_ien ? bus_wdata[IER_BITS-1:0] : ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctl_q <= '0;
         msta_q <= '0;
         scr_q  <= '0;
         rbr_q  <= '0;
         ien_q  <= '0;
         mctl_q <= '0;
         dr_q   <= 1'b0;
         bi_q   <= 1'b0;
         thre_q <= 1'b1;
         temt_q <= 1'b1;
         tx_v_q <= 1'b0;
         tx_b_q <= '0;
      end else begin
         rbr_q  <= rbr_n;
         dr_q   <= dr_n;
         bi_q   <= bi_n;
         ien_q  <= ien_n;
         thre_q <= thre_q | wr_thr;
         temt_q <= temt_q | wr_thr;
         tx_v_q <= wr_thr;
         if (wr_thr)  tx_b_q <= bus_wdata;
         if (wr_lctl) lctl_q <= bus_wdata;
         if (wr_mctl) mctl_q <= bus_wdata[MCR_BITS-1:0];
         if (wr_msta) msta_q <= bus_wdata;
         if (wr_scr)  scr_q  <= bus_wdata;
      end
   end

   sio_divlatch #(.DIV_BYTES(DIV_BYTES)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_dll),
      .wr_hi   (wr_dlh),
      .wdata   (bus_wdata),
      .div_lo  (div_lo),
      .div_hi  (div_hi),
      .div_val (div_val)
   );

   sio_irq_eval u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_tx   (wr_thr),
      .set_ien  (wr_ien),
      .thre_nx  (thre_q | wr_thr),
      .clr_rd   (rd_iid),
      .dr_nx    (dr_n),
      .rx_en_nx (ien_n[IE_RX]),
      .tx_en_nx (ien_n[IE_TX]),
      .id_q     (irq_id),
      .irq_q    (irq)
   );

   sio_modem_view #(.MCR_BITS(MCR_BITS), .LOOP_EN(LOOP_EN)) u_mview (
      .mctl (mctl_q),
      .msta (msta_q),
      .view (msta_view)
   );

   assign lsta = {1'b0, temt_q, thre_q, bi_q, 3'b000, dr_q};

   always_comb begin
      case (bus_addr)
         A_DATA:  bus_rdata = dlab ? div_lo : rbr_q;
         A_IEN:   bus_rdata = dlab ? div_hi : 8'(ien_q);
         A_IID:   bus_rdata = irq_id;
         A_LCTL:  bus_rdata = lctl_q;
         A_MCTL:  bus_rdata = 8'(mctl_q);
         A_LSTA:  bus_rdata = lsta;
         A_MSTA:  bus_rdata = msta_view;
         default: bus_rdata = scr_q;
      endcase
   end

   assign rx_ready    = ~dr_q;
   assign tx_valid    = tx_v_q;
   assign tx_byte     = tx_b_q;
   assign cfg_divisor = 16'(div_val);
   assign cfg_line    = lctl_q;

   AST_RX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_q && ien_q[IE_RX]) |-> irq_id == ID_RX); // R4
   AST_EMPTY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_thr |=> (tx_valid && lsta[6:5] == 2'b11)); // R6
   AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !rx_break) |=> $stable(rbr_q)); // R8
   AST_READ_CLEARS_DR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rbr && !rx_take && !rx_break) |=> !dr_q && !bi_q); // R8
   AST_BREAK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_break |=> (rbr_q == 8'h00 && bi_q && dr_q)); // R9
endmodule

// File: tb/sio_regbank_bench.sv
module sio_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rx_valid = 1'b0, rx_break = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_byte, cfg_line, irq_id;
   logic [15:0] cfg_divisor;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   sio_regbank u_sio_regbank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
      .cfg_divisor(cfg_divisor), .cfg_line(cfg_line), .irq_id(irq_id),
      .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd_reg(3'd5, v); chk("R1 lsr", v, 8'h60);
      rd_reg(3'd2, v); chk("R1 id", v, 8'h01);
      chk("R1 irq", irq, 0);
      chk("R1 rx_ready", rx_ready, 1);
      rd_reg(3'd1, v); chk("R1 ier", v, 8'h00);
      chk("R1 divisor", cfg_divisor, 16'h0000);
   endtask

   task automatic t_divisor;
      logic [7:0] v;
      wr_reg(3'd3, 8'h83);
      wr_reg(3'd0, 8'h34);
      chk("R2 no tx strobe in latch mode", tx_valid, 0);
      wr_reg(3'd1, 8'h12);
      rd_reg(3'd0, v); chk("R2 div lo", v, 8'h34);
      rd_reg(3'd1, v); chk("R2 div hi", v, 8'h12);
      chk("R2 cfg_divisor", cfg_divisor, 16'h1234);
      wr_reg(3'd3, 8'h03);
      rd_reg(3'd1, v); chk("R2 ier untouched by latch writes", v, 8'h00);
      rd_reg(3'd3, v); chk("R11 lcr readback", v, 8'h03);
      chk("R2 irq still idle", irq, 0);
   endtask

   task automatic t_ier_pending;
      logic [7:0] v;
      wr_reg(3'd1, 8'hFF);
      rd_reg(3'd1, v); chk("R3 ier low nibble", v, 8'h0F);
      chk("R7 R12 id after ier write", irq_id, 8'h02);
      chk("R4 irq with tx id", irq, 1);
      rd_reg(3'd2, v); chk("R5 id read", v, 8'h02);
      chk("R5 id after clear", irq_id, 8'h01);
      chk("R5 irq after clear", irq, 0);
      rd_reg(3'd2, v); chk("R5 second id read", v, 8'h01);
   endtask

   task automatic t_tx;
      logic [7:0] v;
      wr_reg(3'd0, 8'hA5);
      chk("R6 tx_valid", tx_valid, 1);
      chk("R6 tx_byte", tx_byte, 8'hA5);
      chk("R6 id set", irq_id, 8'h02);
      @(negedge clk);
      chk("R6 tx_valid one cycle", tx_valid, 0);
      rd_reg(3'd5, v); chk("R6 lsr empty bits", v, 8'h60);
      rd_reg(3'd2, v); chk("R5 clear after tx", irq_id, 8'h01);
   endtask

   task automatic t_rx_priority;
      logic [7:0] v;
      wr_reg(3'd0, 8'h11);
      rx_push(8'h5A);
      chk("R4 rx over tx", irq_id, 8'h04);
      chk("R8 rx_ready low", rx_ready, 0);
      rx_push(8'h77);
      rd_reg(3'd2, v); chk("R5 id read shows rx", v, 8'h04);
      chk("R5 rx id read keeps pending", irq_id, 8'h04);
      rd_reg(3'd5, v); chk("R8 lsr data ready", v, 8'h61);
      rd_reg(3'd0, v); chk("R8 held byte not overwritten", v, 8'h5A);
      chk("R8 rx_ready after read", rx_ready, 1);
      chk("R5 tx pending returns", irq_id, 8'h02);
      rd_reg(3'd2, v); chk("R5 clear", irq_id, 8'h01);
   endtask

   task automatic t_ier_disabled;
      logic [7:0] v;
      wr_reg(3'd1, 8'h00);
      wr_reg(3'd0, 8'h22);
      chk("R4 disabled tx gives none", irq_id, 8'h01);
      chk("R4 irq low", irq, 0);
      wr_reg(3'd1, 8'h02);
      chk("R7 re-enable sets id", irq_id, 8'h02);
      rd_reg(3'd2, v); chk("R5 read id", v, 8'h02);
      rx_push(8'h33);
      chk("R4 rx not enabled", irq_id, 8'h01);
      rd_reg(3'd0, v); chk("R8 read byte", v, 8'h33);
   endtask

   task automatic t_break;
      logic [7:0] v;
      @(negedge clk); rx_break = 1'b1;
      @(negedge clk); rx_break = 1'b0;
      rd_reg(3'd5, v); chk("R9 lsr after break", v, 8'h71);
      rd_reg(3'd0, v); chk("R9 rbr zero", v, 8'h00);
      rd_reg(3'd5, v); chk("R8 R9 bits cleared", v, 8'h60);
   endtask

   task automatic t_loopback;
      logic [7:0] v;
      wr_reg(3'd4, 8'hFF);
      rd_reg(3'd4, v); chk("R10 mcr width", v, 8'h1F);
      rd_reg(3'd6, v); chk("R10 loop all", v, 8'hF0);
      wr_reg(3'd4, 8'h15);
      wr_reg(3'd6, 8'hAB);
      rd_reg(3'd6, v); chk("R10 loop mix", v, 8'h60);
      wr_reg(3'd4, 8'h1A);
      rd_reg(3'd6, v); chk("R10 loop bit1", v, 8'h90);
      wr_reg(3'd4, 8'h00);
      rd_reg(3'd6, v); chk("R11 msr plain", v, 8'hAB);
   endtask

   task automatic t_misc;
      logic [7:0] v;
      wr_reg(3'd7, 8'h3C);
      rd_reg(3'd7, v); chk("R11 scratch", v, 8'h3C);
      wr_reg(3'd5, 8'h00);
      rd_reg(3'd5, v); chk("R11 lsr write ignored", v, 8'h60);
      wr_reg(3'd2, 8'hFF);
      rd_reg(3'd2, v); chk("R11 id write ignored", v, 8'h01);
      chk("R11 cfg_line", cfg_line, 8'h03);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_divisor;
      t_ier_pending;
      t_tx;
      t_rx_priority;
      t_ier_disabled;
      t_break;
      t_loopback;
      t_misc;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule